// File: doc/BRIEF.md
# Processor Mode Control Sequencer

This block sits beside the datapath of a small 8-bit processor core. It turns two active-low control pins into one of four operating modes. The clear pin low with the wait pin high holds the core in reset. Both pins low select memory loading. The clear pin high with the wait pin low freezes the core. Both pins high let it execute. The block drives the machine-cycle timing pulses and reports the kind of machine cycle under way as a state code. It decides, at each cycle boundary, whether the next cycle is a fetch, an execute, a DMA transfer or an interrupt acknowledge.

When the core leaves reset, the block inserts one hidden machine cycle that clears the 16-bit pointer register. In the loading mode the core does no work. Each DMA-in request stores the presented byte at the next memory location, starting at zero, so a program can be placed in memory without any loader code. Once the core runs, interrupts stay blocked until one execute or DMA cycle has completed. This gives the first instructions the chance to turn interrupts off.

Top module: `mode_ctl_seq`

## Requirements
- R1: The `mode` output shows the mode selected by the pins on the previous clock edge, with reset = 00, load = 01, pause = 10 and run = 11.
- R2: While `mode` is 00, `tpa`, `tpb` and `mem_wr` are low, `mem_wdata` is zero and `state_code` is 00.
- R3: On the first clock edge that finds the pins out of the reset combination, a hidden cycle of `CYCLE_CLKS` clocks begins, during which neither timing pulse appears. In run mode, `run_start` pulses on the edge `CYCLE_CLKS` clocks later, with `mem_addr` at zero.
- R4: Every machine cycle other than the hidden cycle and idle cycles raises `tpa` for one clock in phase 1 and `tpb` for one clock in phase `CYCLE_CLKS`-2. Consecutive `tpa` pulses in run are `CYCLE_CLKS` clocks apart.
- R5: State codes are fetch/hidden/reset = 00, execute/idle = 01, DMA = 10 and interrupt = 11. In run with no request pending, the first cycle is a fetch at address 0, followed by an execute, then a fetch at address 1.
- R6: If DMA-in is requested when run is entered, the first cycle is a DMA cycle at address 0 that writes `dma_data`.
- R7: In load mode, each DMA cycle pulses `mem_wr` once in phase `CYCLE_CLKS`-2 with `dma_data` at sequential addresses from 0. Cycles without a request are idle (code 01) and carry no timing pulses.
- R8: In pause mode, every output except `mode` holds its value, and neither DMA nor interrupt is taken. After release, the cycle resumes from the phase where it stopped.
- R9: An interrupt request is taken only at the end of an execute or DMA cycle. It is not taken before the first such cycle in run has completed.
- R10: Reset enables interrupts and taking an interrupt disables them, so at most one interrupt cycle occurs per reset.
- R11: Interrupt requests are ignored in load mode.
- R12: The load/program pointer is `ADDR_W` bits wide and wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, same effect as the reset mode |
| clear_n | input | 1 | Active-low clear control pin |
| wait_n | input | 1 | Active-low wait control pin |
| dma_in_req | input | 1 | DMA-in request |
| int_req | input | 1 | Interrupt request |
| dma_data | input | DATA_W | Byte to store during DMA-in cycles |
| mode | output | 2 | Registered mode code |
| state_code | output | 2 | Kind of the current machine cycle |
| tpa | output | 1 | First timing pulse |
| tpb | output | 1 | Second timing pulse |
| mem_addr | output | ADDR_W | Address of the current fetch or DMA cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Data written by DMA-in |
| run_start | output | 1 | One-clock pulse when execution starts after the hidden cycle |

## Verification
The bench builds the block with `ADDR_W` = 4 and `CYCLE_CLKS` = 8. The narrow pointer brings the address wrap within a load of nineteen bytes, and the eight-clock cycle matches the stated machine-cycle length. Directed runs cover fetch-first and DMA-first starts, the delayed first interrupt, a pause with pending requests, and a load with interrupts held high. A random phase then exercises the pin decode across all four modes.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [1:0] {
    MODE_RESET = 2'b00,
    MODE_LOAD  = 2'b01,
    MODE_PAUSE = 2'b10,
    MODE_RUN   = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_INIT,
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_DMA,
    ST_INT
  } cyc_e;

  // externally visible cycle code
  function automatic logic [1:0] sc_of(cyc_e s);
    logic [1:0] r;
    case (s)
      ST_EXEC, ST_IDLE: r = 2'b01;
      ST_DMA:           r = 2'b10;
      ST_INT:           r = 2'b11;
      default:          r = 2'b00;
    endcase
    return r;
  endfunction

  // cycles that drive the timing pulses
  function automatic logic has_pulses(cyc_e s);
    return (s == ST_FETCH) || (s == ST_EXEC) || (s == ST_DMA) || (s == ST_INT);
  endfunction

endpackage

// File: rtl/mcs_mode_decode.sv
module mcs_mode_decode
  import mcs_pkg::*;
(
  input  logic  clear_n,
  input  logic  wait_n,
  output mode_e dec
);
  always_comb begin
    case ({clear_n, wait_n})
      2'b01:   dec = MODE_RESET;
      2'b00:   dec = MODE_LOAD;
      2'b10:   dec = MODE_PAUSE;
      default: dec = MODE_RUN;
    endcase
  end
endmodule

// File: rtl/mcs_phase_ctr.sv
module mcs_phase_ctr #(
  parameter int CYCLE_CLKS = 8,
  parameter int PH_W       = 3
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            adv,
  output logic [PH_W-1:0] ph_nxt,
  output logic            last
);
  logic [PH_W-1:0] ph_q;

  assign last = (ph_q == PH_W'(CYCLE_CLKS - 1));

  always_comb begin
    if (clr)      ph_nxt = '0;
    else if (adv) ph_nxt = last ? '0 : ph_q + 1'b1;
    else          ph_nxt = ph_q;
  end

  always_ff @(posedge clk) ph_q <= ph_nxt;
endmodule

// File: rtl/mcs_addr_ptr.sv
module mcs_addr_ptr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (clr)      ptr <= '0;
    else if (inc) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/mode_ctl_seq.sv
module mode_ctl_seq
  import mcs_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int CYCLE_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_n,
  input  logic              wait_n,
  input  logic              dma_in_req,
  input  logic              int_req,
  input  logic [DATA_W-1:0] dma_data,
  output logic [1:0]        mode,
  output logic [1:0]        state_code,
  output logic              tpa,
  output logic              tpb,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              run_start
);
  localparam int PH_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
  localparam logic [PH_W-1:0] TPA_PH = PH_W'(1);
  localparam logic [PH_W-1:0] TPB_PH = PH_W'(CYCLE_CLKS - 2);

  mode_e dec, mode_q;
  cyc_e  st_q, nxt_st;
  logic  ie_q, armed_q;
  logic  in_reset, leave, hold, adv, end_cyc, ptr_inc;
  logic  ph_last;
  logic [PH_W-1:0]   ph_nxt;
  logic [ADDR_W-1:0] ptr;

  mcs_mode_decode u_dec (.clear_n(clear_n), .wait_n(wait_n), .dec(dec));

  assign in_reset = rst || (dec == MODE_RESET);
  assign leave    = !in_reset && (st_q == ST_RESET);
  assign hold     = !in_reset && !leave && (dec == MODE_PAUSE);
  assign adv      = !in_reset && !leave && !hold;
  assign end_cyc  = adv && ph_last;

  mcs_phase_ctr #(.CYCLE_CLKS(CYCLE_CLKS), .PH_W(PH_W)) u_ph (
    .clk(clk), .clr(in_reset || leave), .adv(adv),
    .ph_nxt(ph_nxt), .last(ph_last)
  );

  // next machine cycle, chosen at the cycle boundary
  always_comb begin
    nxt_st = st_q;
    if (in_reset) begin
      nxt_st = ST_RESET;
    end else if (leave) begin
      nxt_st = ST_INIT;
    end else if (end_cyc) begin
      if (dec == MODE_LOAD) begin
        nxt_st = dma_in_req ? ST_DMA : ST_IDLE;
      end else if (st_q == ST_FETCH) begin
        nxt_st = ST_EXEC;
      end else if (dma_in_req) begin
        nxt_st = ST_DMA;
      end else if (int_req && ie_q &&
                   (armed_q || st_q == ST_EXEC || st_q == ST_DMA)) begin
        nxt_st = ST_INT;
      end else begin
        nxt_st = ST_FETCH;
      end
    end
  end

  assign ptr_inc = end_cyc && (nxt_st == ST_FETCH || nxt_st == ST_DMA);

  mcs_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .clr(in_reset || leave), .inc(ptr_inc), .ptr(ptr)
  );

  always_ff @(posedge clk) begin
    mode_q <= rst ? MODE_RESET : dec;
    st_q   <= nxt_st;
    if (in_reset) begin
      ie_q    <= 1'b1;
      armed_q <= 1'b0;
    end else if (end_cyc) begin
      if (nxt_st == ST_INT) ie_q <= 1'b0;
      if (dec == MODE_RUN && (st_q == ST_EXEC || st_q == ST_DMA)) armed_q <= 1'b1;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (in_reset) begin
      tpa        <= 1'b0;
      tpb        <= 1'b0;
      mem_wr     <= 1'b0;
      mem_wdata  <= '0;
      state_code <= sc_of(ST_RESET);
      run_start  <= 1'b0;
      mem_addr   <= '0;
    end else if (leave) begin
      tpa        <= 1'b0;
      tpb        <= 1'b0;
      mem_wr     <= 1'b0;
      mem_wdata  <= '0;
      state_code <= sc_of(ST_INIT);
      run_start  <= 1'b0;
    end else if (adv) begin
      tpa        <= (ph_nxt == TPA_PH) && has_pulses(nxt_st);
      tpb        <= (ph_nxt == TPB_PH) && has_pulses(nxt_st);
      mem_wr     <= (ph_nxt == TPB_PH) && (nxt_st == ST_DMA);
      if ((ph_nxt == TPB_PH) && (nxt_st == ST_DMA)) mem_wdata <= dma_data;
      state_code <= sc_of(nxt_st);
      run_start  <= end_cyc && (st_q == ST_INIT) && (dec == MODE_RUN);
      if (ptr_inc) mem_addr <= ptr;
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/mcs_chk.sv
module mcs_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic [1:0]        state_code,
  input logic              tpa,
  input logic              tpb,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              run_start
);
  logic int_seen;

  always_ff @(posedge clk) begin
    if (rst || mode == 2'b00)   int_seen <= 1'b0;
    else if (state_code == 2'b11) int_seen <= 1'b1;
  end

  a_r2_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |-> !tpa && !tpb && !mem_wr && mem_wdata == '0);

  a_r4_tpa_single: assert property (@(posedge clk) disable iff (rst)
    tpa |=> (!tpa || mode == 2'b10));

  a_r7_wr_in_dma: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> state_code == 2'b10);

  a_r8_pause_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && $past(mode) == 2'b10) |->
      $stable(mem_addr) && $stable(state_code) && $stable(tpa) && $stable(mem_wr));

  a_r11_int_run_only: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b11 && $past(state_code) != 2'b11) |-> mode == 2'b11);

  a_r10_one_int: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b11 && $past(state_code) != 2'b11) |-> !int_seen);

  a_r3_start_addr0: assert property (@(posedge clk) disable iff (rst)
    run_start |-> mem_addr == '0 && state_code != 2'b11);
endmodule

bind mode_ctl_seq mcs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .state_code(state_code), .tpa(tpa),
  .tpb(tpb), .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
  .run_start(run_start)
);

// File: tb/tb_mode_ctl_seq.sv
`timescale 1ns/100ps
module tb_mode_ctl_seq;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int CYC = 8;

  logic clk = 1'b0, rst = 1'b1, clear_n = 1'b0, wait_n = 1'b1;
  logic dma_in_req = 1'b0, int_req = 1'b0;
  logic [DW-1:0] dma_data = '0;
  logic [1:0] mode, state_code;
  logic tpa, tpb, mem_wr, run_start;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mode_ctl_seq #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_CLKS(CYC)) dut (
    .clk(clk), .rst(rst), .clear_n(clear_n), .wait_n(wait_n),
    .dma_in_req(dma_in_req), .int_req(int_req), .dma_data(dma_data),
    .mode(mode), .state_code(state_code), .tpa(tpa), .tpb(tpb),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .run_start(run_start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(input logic c, input logic w);
    if (!c && w)  return 2'b00;
    if (!c && !w) return 2'b01;
    if (c && !w)  return 2'b10;
    return 2'b11;
  endfunction

  task automatic go_reset();
    clear_n = 1'b0; wait_n = 1'b1; dma_in_req = 1'b0; int_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int first_rs, bad_init, bad_gap, bad_tpb, last_rise, k, p, mism, nxt_rise;
    int first_int, n_int, writes, nwr, ibad, pbad, mbad, qbad;
    logic ptpa, ptpb;
    logic [1:0] s_sc, pm, ps;
    logic [AW-1:0] s_addr;
    logic s_tpa, s_wr, pc, pw;
    void'($urandom(32'd1802));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R2)
    chk(mode == 2'b00, "R1 reset code", int'(mode), 0);
    chk(!tpa && !tpb && !mem_wr, "R2 pulses low in reset", int'({tpa, tpb, mem_wr}), 0);
    chk(mem_wdata == 0 && state_code == 2'b00, "R2 data and code zero", int'(mem_wdata), 0);

    // run start, no requests (R3 R4 R5)
    go_reset();
    clear_n = 1'b1; wait_n = 1'b1;
    first_rs = 0; bad_init = 0; bad_gap = 0; bad_tpb = 0; last_rise = 0;
    ptpa = 1'b0; ptpb = 1'b0;
    for (k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (k == 1) chk(mode == 2'b11, "R1 run code", int'(mode), 3);
      if (run_start && first_rs == 0) first_rs = k;
      if (k <= CYC && (tpa || tpb)) bad_init++;
      if (k == CYC + 1) chk(state_code == 2'b00 && mem_addr == 0, "R5 first fetch at 0", int'(mem_addr), 0);
      if (k == 2 * CYC + 1) chk(state_code == 2'b01, "R5 execute follows", int'(state_code), 1);
      if (k == 3 * CYC + 1) chk(state_code == 2'b00 && mem_addr == 1, "R5 second fetch at 1", int'(mem_addr), 1);
      if (tpa && !ptpa) begin
        if (last_rise > 0 && k - last_rise != CYC) bad_gap++;
        last_rise = k;
      end
      if (tpb && !ptpb && k - last_rise != CYC - 3) bad_tpb++;
      ptpa = tpa; ptpb = tpb;
    end
    chk(first_rs == CYC + 1, "R3 run_start after hidden cycle", first_rs, CYC + 1);
    chk(bad_init == 0, "R3 no pulses in hidden cycle", bad_init, 0);
    chk(bad_gap == 0, "R4 tpa spacing", bad_gap, 0);
    chk(bad_tpb == 0, "R4 tpb phase", bad_tpb, 0);

    // pause with pending requests (R8)
    p = 5 + int'($urandom % 10);
    s_sc = state_code; s_addr = mem_addr; s_tpa = tpa; s_wr = mem_wr;
    wait_n = 1'b0; int_req = 1'b1; dma_in_req = 1'b1;
    mism = 0;
    for (int j = 1; j <= p; j++) begin
      @(negedge clk);
      if (j == 1) chk(mode == 2'b10, "R1 pause code", int'(mode), 2);
      if (state_code != s_sc || mem_addr != s_addr || tpa != s_tpa || mem_wr != s_wr) mism++;
      if (j == p) begin wait_n = 1'b1; int_req = 1'b0; dma_in_req = 1'b0; end
    end
    chk(mism == 0, "R8 outputs frozen in pause", mism, 0);
    nxt_rise = 0;
    for (int j = 1; j <= 2 * CYC; j++) begin
      @(negedge clk);
      if (tpa && !ptpa && nxt_rise == 0) nxt_rise = 60 + p + j;
      ptpa = tpa;
    end
    chk(nxt_rise - last_rise == CYC + p, "R8 phase resumes", nxt_rise - last_rise, CYC + p);

    // delayed first interrupt, single interrupt (R9 R10)
    go_reset();
    int_req = 1'b1; clear_n = 1'b1; wait_n = 1'b1;
    first_int = 0; n_int = 0; ps = 2'b00;
    for (k = 1; k <= 90; k++) begin
      @(negedge clk);
      if (state_code == 2'b11 && ps != 2'b11) begin
        n_int++;
        if (first_int == 0) first_int = k;
      end
      ps = state_code;
    end
    chk(first_int == 3 * CYC + 1, "R9 interrupt after first execute", first_int, 3 * CYC + 1);
    chk(n_int == 1, "R10 one interrupt per reset", n_int, 1);

    // DMA pending at run entry (R6 R9)
    go_reset();
    dma_in_req = 1'b1; int_req = 1'b1; dma_data = 8'($urandom);
    clear_n = 1'b1; wait_n = 1'b1;
    nwr = 0;
    for (k = 1; k <= 2 * CYC + 2; k++) begin
      @(negedge clk);
      if (k == CYC + 1) chk(state_code == 2'b10 && mem_addr == 0, "R6 first cycle is DMA at 0", int'(state_code), 2);
      if (mem_wr) begin
        nwr++;
        chk(mem_wdata == dma_data, "R6 DMA data written", int'(mem_wdata), int'(dma_data));
        dma_in_req = 1'b0;
      end
      if (k == 2 * CYC + 1) chk(state_code == 2'b11, "R9 interrupt after first DMA", int'(state_code), 3);
    end
    chk(nwr == 1, "R6 single write", nwr, 1);

    // load with wrap and interrupts ignored (R7 R11 R12)
    go_reset();
    clear_n = 1'b0; wait_n = 1'b0; dma_in_req = 1'b1; int_req = 1'b1;
    dma_data = 8'($urandom);
    writes = 0; ibad = 0; pbad = 0;
    for (k = 1; k <= 400 && writes < (1 << AW) + 3; k++) begin
      @(negedge clk);
      if (k == 1) chk(mode == 2'b01, "R1 load code", int'(mode), 1);
      if (state_code == 2'b11) ibad++;
      if ((tpa || tpb) && state_code != 2'b10) pbad++;
      if (mem_wr) begin
        chk(mem_addr == AW'(writes) && mem_wdata == dma_data,
            writes >= (1 << AW) ? "R12 wrapped load address" : "R7 load address and data",
            int'(mem_addr), writes % (1 << AW));
        writes++;
        if (writes == (1 << AW) + 3) dma_in_req = 1'b0;
        else dma_data = 8'($urandom);
      end
    end
    chk(writes == (1 << AW) + 3, "R7 load byte count", writes, (1 << AW) + 3);
    nwr = 0;
    for (k = 1; k <= 3 * CYC; k++) begin
      @(negedge clk);
      if (mem_wr) nwr++;
      if (state_code == 2'b11) ibad++;
      if ((tpa || tpb) && state_code != 2'b10) pbad++;
      if (k > CYC + 2 && state_code != 2'b01) pbad++;
    end
    chk(nwr == 0, "R7 no write without request", nwr, 0);
    chk(pbad == 0, "R7 idle cycles quiet", pbad, 0);
    chk(ibad == 0, "R11 interrupt ignored in load", ibad, 0);

    // random pin activity (R1 R2)
    mbad = 0; qbad = 0;
    pc = clear_n; pw = wait_n;
    for (k = 0; k < 600; k++) begin
      if ($urandom % 6 == 0) begin
        clear_n = 1'($urandom); wait_n = 1'($urandom);
      end
      dma_in_req = 1'($urandom); int_req = 1'($urandom);
      dma_data = 8'($urandom);
      pc = clear_n; pw = wait_n;
      @(negedge clk);
      pm = exp_mode(pc, pw);
      if (mode != pm) mbad++;
      if (mode == 2'b00 && (tpa || tpb || mem_wr || mem_wdata != 0)) qbad++;
    end
    chk(mbad == 0, "R1 random mode decode", mbad, 0);
    chk(qbad == 0, "R2 random reset quiet", qbad, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule